// File: doc/BRIEF.md
# I2C Write-Only Target Receiver with Clock Stretching

This block is the receive side of an I2C target that accepts write transfers with 7-bit addressing. It synchronises the open-drain SCL and SDA lines and finds Start, repeated Start and Stop conditions. It matches the address byte against a programmed address and shifts data bytes into a one-byte receive buffer. It answers each byte in the acknowledge slot, and it can hold SCL low so that firmware has time to act. A down-counter of expected bytes decides whether the normal acknowledge value or a separate end-of-count value goes out.

Received bytes leave through a valid/ready stream. `rx_valid` stays high while the buffer holds a byte. A transfer takes place in any clock cycle where both `rx_valid` and `rx_ready` are high, and that transfer empties the buffer. While `rx_ready` stays low the byte is kept, and the block pushes back on the bus. If stretching is allowed, it holds SCL low after the 7th falling edge of the next byte. If stretching is disabled, it refuses that byte with a NACK. A `clr_buf` pulse drops the buffered byte without a transfer.

Firmware controls the block through plain control pins and single-cycle clear pulses. The flags are exported as level outputs. `irq` is high whenever the stretch, acknowledge-time or NACK flag is set.

Top module: `i2c_rx_target`

## Requirements
- R1: A Start is an SDA fall while SCL is high, and a Stop is an SDA rise while SCL is high. If the 7 address bits (sent MSB first) differ from `own_addr`, the block drives no acknowledge, stores nothing and ignores the bus until the next Start.
- R2: A matching address byte with bit 0 (R/W) = 0 is answered with the value of `ack_data`. Driving SDA low in the 9th SCL pulse means ACK. A matching address byte with R/W = 1 gets no acknowledge.
- R3: With `addr_to_buf` = 0 the matched address appears on `addr_q` and the buffer is untouched. With `addr_to_buf` = 1 the full address byte ({address, R/W}) goes into the buffer and `rx_valid` rises.
- R4: With `addr_hold_en` = 1 and `stretch_dis` = 0, a matched address sets `stretch_flag` and `irq`. SCL is then held low from the 8th falling edge until `clr_stretch` is pulsed, and the acknowledge value is already on SDA while SCL is held.
- R5: Each accepted data byte (MSB first) sets `rx_valid` with the byte on `rx_data`. The byte stays until a cycle with `rx_ready` = 1 or a `clr_buf` pulse.
- R6: If the buffer is still full at the 7th rising edge of a new data byte and `stretch_dis` = 0, `stretch_flag` is set and SCL is held low after the 7th falling edge. Reading the buffer releases SCL and clears `stretch_flag` without firmware action.
- R7: If the buffer is still full when a data byte completes and `stretch_dis` = 1, the byte is refused with a NACK. `nack_flag` is set, the buffer keeps its old byte, and the block ignores the bus until the next Start.
- R8: With `ack_hold_en` = 1 and `stretch_dis` = 0, each accepted data byte sets `stretch_flag` and `acktime_flag` and holds SCL low before the acknowledge slot. SCL is released only after both flags are cleared, and the acknowledge sent is the value selected while SCL was held.
- R9: A data byte is answered with `ack_data` while `cnt_q` is nonzero and with `ack_eoc` once `cnt_q` is zero. `cnt_q` drops by one for each data byte that is acknowledged, never goes below zero, and is loaded from `cnt_init` by `cnt_load`.
- R10: `sda_oe` changes only while the synchronised SCL is low.
- R11: With `stretch_dis` = 1, no hold point (address, acknowledge or overflow) sets `stretch_flag` or holds SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (open-drain enable) |
| sda_oe | output | 1 | Pull SDA low (open-drain enable) |
| own_addr | input | 7 | Programmed target address |
| stretch_dis | input | 1 | Disables all clock stretching |
| addr_hold_en | input | 1 | Hold after a matched address |
| ack_hold_en | input | 1 | Hold before each data acknowledge |
| addr_to_buf | input | 1 | Place matched address byte in the receive buffer |
| ack_data | input | 1 | Acknowledge value while count is nonzero (0 = ACK) |
| ack_eoc | input | 1 | Acknowledge value once count is zero (1 = NACK) |
| cnt_load | input | 1 | Load pulse for the byte counter |
| cnt_init | input | CW | Byte counter load value |
| cnt_q | output | CW | Remaining byte count |
| clr_buf | input | 1 | Drop the buffered byte |
| clr_stretch | input | 1 | Clear the stretch flag |
| clr_acktime | input | 1 | Clear the acknowledge-time flag |
| clr_nack | input | 1 | Clear the NACK flag |
| rx_valid | output | 1 | Receive buffer holds a byte |
| rx_ready | input | 1 | Consumer takes the byte |
| rx_data | output | 8 | Buffered byte |
| addr_q | output | 7 | Last matched address |
| stretch_flag | output | 1 | Clock stretch requested |
| acktime_flag | output | 1 | Acknowledge-time hold pending |
| nack_flag | output | 1 | Overflow NACK was sent |
| irq | output | 1 | Any of the three flags set |

## Verification
A wrong bit count or a wrong state shows up at the ports within one byte. The acknowledge then lands in the wrong SCL pulse, or no acknowledge comes at all, and a master sampling SDA in the 9th pulse sees it. A stretch flag set or cleared at the wrong moment shows up within a few clocks as SCL held where it should run, or running where it should be held. A counter error shows up as a wrong acknowledge on the byte where the count reaches zero. A buffer handshake error shows as a lost or repeated byte at the next `rx_valid` transfer.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } rx_state_e;

  typedef struct packed {
    logic scl;
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_ev_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output i2c_rx_pkg::bus_ev_t ev
);
  localparam int NL = 2;

  logic [NL-1:0] raw, now_q, prev_q;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign now_q[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= now_q;
  end

  always_comb begin
    ev.scl      = now_q[0];
    ev.sda      = now_q[1];
    ev.scl_rise = now_q[0] & ~prev_q[0];
    ev.scl_fall = ~now_q[0] & prev_q[0];
    ev.start    = now_q[0] & prev_q[0] & prev_q[1] & ~now_q[1];
    ev.stop     = now_q[0] & prev_q[0] & ~prev_q[1] & now_q[1];
  end

endmodule

// File: rtl/i2c_byte_cnt.sv
module i2c_byte_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] init,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= init;
    else if (dec && cnt != '0)  cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);

  // R9: the count never wraps below zero
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == '0 && !$past(load)) |-> cnt == '0);

endmodule

// File: rtl/i2c_rx_target.sv
module i2c_rx_target #(
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic [6:0]    own_addr,
  input  logic          stretch_dis,
  input  logic          addr_hold_en,
  input  logic          ack_hold_en,
  input  logic          addr_to_buf,
  input  logic          ack_data,
  input  logic          ack_eoc,
  input  logic          cnt_load,
  input  logic [CW-1:0] cnt_init,
  output logic [CW-1:0] cnt_q,
  input  logic          clr_buf,
  input  logic          clr_stretch,
  input  logic          clr_acktime,
  input  logic          clr_nack,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [7:0]    rx_data,
  output logic [6:0]    addr_q,
  output logic          stretch_flag,
  output logic          acktime_flag,
  output logic          nack_flag,
  output logic          irq
);
  import i2c_rx_pkg::*;

  localparam int BW    = 8;
  localparam int BIT_W = $clog2(BW);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BW - 1);
  localparam logic [BIT_W-1:0] SEVENTH  = BIT_W'(BW - 2);

  bus_ev_t ev;
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .scl_i(scl_i),
    .sda_i(sda_i),
    .ev   (ev)
  );

  rx_state_e        st;
  logic [BIT_W-1:0] bitc;
  logic [BW-2:0]    shreg;
  logic [BW-1:0]    byte_in;
  logic [BW-1:0]    buf_q;
  logic             buf_full, ack_rose, sda_drv, scl_hold, ovf_wait;
  logic             stretch_q, acktime_q, nack_q;
  logic [6:0]       addr_r;
  logic             cnt_zero, cnt_dec, ack_val, hold_ok, rd_fire, drop;
  logic             byte_done, seventh_rise, addr_ok, data_ok, data_ovf, addr_hit;

  assign byte_in      = {shreg, ev.sda};
  assign addr_hit     = (byte_in[BW-1:1] == own_addr) && !byte_in[0];
  assign hold_ok      = !stretch_dis;
  assign rd_fire      = buf_full && rx_ready;
  assign drop         = rd_fire || clr_buf;
  assign byte_done    = ev.scl_rise && bitc == LAST_BIT && (st == ST_ADDR || st == ST_DATA);
  assign seventh_rise = ev.scl_rise && bitc == SEVENTH && st == ST_DATA;
  assign addr_ok      = byte_done && st == ST_ADDR && addr_hit;
  assign data_ok      = byte_done && st == ST_DATA && !buf_full;
  assign data_ovf     = byte_done && st == ST_DATA && buf_full;

  always_comb begin
    if (st == ST_DATA_ACK && cnt_zero) ack_val = ack_eoc;
    else                               ack_val = ack_data;
  end

  assign cnt_dec = (st == ST_DATA_ACK) && ev.scl_rise && !ack_rose && sda_drv;

  i2c_byte_cnt #(.W(CW)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .load (cnt_load),
    .init (cnt_init),
    .dec  (cnt_dec),
    .cnt  (cnt_q),
    .zero (cnt_zero)
  );

  // Bus sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bitc     <= '0;
      shreg    <= '0;
      ack_rose <= 1'b0;
      sda_drv  <= 1'b0;
    end else if (ev.stop) begin
      st      <= ST_IDLE;
      sda_drv <= 1'b0;
    end else if (ev.start) begin
      st       <= ST_ADDR;
      bitc     <= '0;
      ack_rose <= 1'b0;
      sda_drv  <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_DATA: begin
          if (ev.scl_rise) begin
            shreg <= byte_in[BW-2:0];
            bitc  <= bitc + BIT_W'(1);
            if (bitc == LAST_BIT) begin
              ack_rose <= 1'b0;
              if (st == ST_ADDR) st <= addr_hit ? ST_ADDR_ACK : ST_SKIP;
              else               st <= buf_full ? ST_SKIP : ST_DATA_ACK;
            end
          end
        end
        ST_ADDR_ACK, ST_DATA_ACK: begin
          if (!ev.scl && !ack_rose) sda_drv <= !ack_val;
          if (ev.scl_rise) ack_rose <= 1'b1;
          if (ev.scl_fall && ack_rose) begin
            sda_drv <= 1'b0;
            st      <= ST_DATA;
            bitc    <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  // Receive buffer and address register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      buf_full <= 1'b0;
      addr_r   <= '0;
    end else begin
      if ((addr_ok && addr_to_buf) || data_ok) begin
        buf_q    <= byte_in;
        buf_full <= 1'b1;
      end else if (drop) begin
        buf_full <= 1'b0;
      end
      if (addr_ok && !addr_to_buf) addr_r <= byte_in[BW-1:1];
    end
  end

  // Flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stretch_q <= 1'b0;
      acktime_q <= 1'b0;
      nack_q    <= 1'b0;
      ovf_wait  <= 1'b0;
    end else begin
      if ((addr_ok && addr_hold_en && hold_ok) ||
          (data_ok && ack_hold_en && hold_ok) ||
          (seventh_rise && buf_full && hold_ok))
        stretch_q <= 1'b1;
      else if (clr_stretch || (ovf_wait && !buf_full))
        stretch_q <= 1'b0;

      if (seventh_rise && buf_full && hold_ok) ovf_wait <= 1'b1;
      else if (!buf_full)                      ovf_wait <= 1'b0;

      if (data_ok && ack_hold_en && hold_ok) acktime_q <= 1'b1;
      else if (clr_acktime)                  acktime_q <= 1'b0;

      if (data_ovf)      nack_q <= 1'b1;
      else if (clr_nack) nack_q <= 1'b0;
    end
  end

  // SCL hold: engaged on a falling edge while a hold is pending
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           scl_hold <= 1'b0;
    else if (ev.stop || ev.start)         scl_hold <= 1'b0;
    else if (!(stretch_q || acktime_q))   scl_hold <= 1'b0;
    else if (ev.scl_fall)                 scl_hold <= 1'b1;
  end

  assign scl_oe       = scl_hold;
  assign sda_oe       = sda_drv;
  assign rx_valid     = buf_full;
  assign rx_data      = buf_q;
  assign addr_q       = addr_r;
  assign stretch_flag = stretch_q;
  assign acktime_flag = acktime_q;
  assign nack_flag    = nack_q;
  assign irq          = stretch_q | acktime_q | nack_q;

  // R10: SDA drive moves only in the low phase of SCL
  a_r10_sda_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drv) |-> !$past(ev.scl));

  // R4: SCL is only held while a stretch or acknowledge-time flag is pending
  a_r4_hold_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold) |-> $past(stretch_q || acktime_q));

  // R11: no stretch request arises while stretching is disabled
  a_r11_no_stretch_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stretch_q) |-> !$past(stretch_dis));

  // R7: an overflow NACK leaves the buffer untouched and the bus ignored
  a_r7_nack_keeps_buf: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_q) |-> ($stable(buf_q) && st == ST_SKIP));

  // R5: a buffered byte stays until taken or dropped
  a_r5_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !clr_buf) |=> rx_valid);

endmodule

// File: tb/sim_i2c_rx_target.sv
module sim_i2c_rx_target;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, scl_line, sda_line;
  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  logic [6:0] own_addr = 7'h5A;
  logic stretch_dis = 0, addr_hold_en = 0, ack_hold_en = 0, addr_to_buf = 0;
  logic ack_data = 0, ack_eoc = 1, cnt_load = 0;
  logic [CW-1:0] cnt_init = '0, cnt_q;
  logic clr_buf = 0, clr_stretch = 0, clr_acktime = 0, clr_nack = 0, rx_ready = 0;
  logic rx_valid, stretch_flag, acktime_flag, nack_flag, irq;
  logic [7:0] rx_data;
  logic [6:0] addr_q;

  i2c_rx_target #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr),
    .stretch_dis(stretch_dis), .addr_hold_en(addr_hold_en), .ack_hold_en(ack_hold_en),
    .addr_to_buf(addr_to_buf), .ack_data(ack_data), .ack_eoc(ack_eoc),
    .cnt_load(cnt_load), .cnt_init(cnt_init), .cnt_q(cnt_q), .clr_buf(clr_buf),
    .clr_stretch(clr_stretch), .clr_acktime(clr_acktime), .clr_nack(clr_nack),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .addr_q(addr_q),
    .stretch_flag(stretch_flag), .acktime_flag(acktime_flag), .nack_flag(nack_flag),
    .irq(irq)
  );

  int n_chk = 0, n_fail = 0, r10_viol = 0;
  logic prev_sda_oe = 0, prev_scl = 1;

  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_sda_oe && scl_line && prev_scl) r10_viol++;
    prev_sda_oe = sda_oe;
    prev_scl    = scl_line;
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; tick(1); s = 1'b0; tick(1);
  endtask

  task automatic m_start();
    sda_m = 1; scl_m = 1; tick(6);
    sda_m = 0; tick(6);
    scl_m = 0; tick(4);
  endtask

  task automatic m_stop();
    scl_m = 0; sda_m = 0; tick(4);
    scl_m = 1;
    while (!scl_line) tick(1);
    tick(6); sda_m = 1; tick(6);
  endtask

  task automatic m_bit(input bit b, output bit held);
    sda_m = b; tick(4);
    scl_m = 1; tick(30);
    held = !scl_line;
    if (!held) begin scl_m = 0; tick(4); end
  endtask

  task automatic m_finish();
    while (!scl_line) tick(1);
    tick(4); scl_m = 0; tick(4);
  endtask

  task automatic m_ack(output bit held, output bit acked);
    sda_m = 1; tick(4);
    scl_m = 1; tick(30);
    held  = !scl_line;
    acked = !sda_line;
    if (!held) begin scl_m = 0; tick(4); end
  endtask

  task automatic m_finish_ack(output bit acked);
    while (!scl_line) tick(1);
    tick(2); acked = !sda_line; tick(2);
    scl_m = 0; tick(4);
  endtask

  task automatic m_byte(input logic [7:0] d, output bit acked, output bit held_any);
    bit h;
    held_any = 0;
    for (int i = 7; i >= 0; i--) begin
      m_bit(d[i], h);
      held_any |= h;
    end
    m_ack(h, acked);
    held_any |= h;
  endtask

  task automatic load_cnt(input logic [CW-1:0] v);
    cnt_init = v; pulse(cnt_load);
  endtask

  task automatic t_reset();
    chk("R10 reset scl_oe", scl_oe, 0);
    chk("R10 reset sda_oe", sda_oe, 0);
    chk("R5 reset rx_valid", rx_valid, 0);
    chk("R9 reset cnt_q", cnt_q, 0);
    chk("R4 reset irq", irq, 0);
  endtask

  task automatic t_mismatch();
    bit a, h;
    m_start();
    m_byte(8'h44, a, h);
    chk("R1 foreign address not acked", a, 0);
    m_byte(8'h99, a, h);
    chk("R1 data after mismatch not acked", a, 0);
    chk("R1 nothing stored", rx_valid, 0);
    chk("R1 addr_q untouched", addr_q, 0);
    m_stop();
  endtask

  task automatic t_read_req();
    bit a, h;
    m_start();
    m_byte(8'hB5, a, h);
    chk("R2 read request not acked", a, 0);
    m_stop();
  endtask

  task automatic t_write_count();
    bit a, h;
    load_cnt(2);
    m_start();
    m_byte(8'hB4, a, h);
    chk("R2 matched write acked", a, 1);
    chk("R3 addr_q holds address", addr_q, 7'h5A);
    chk("R3 buffer untouched", rx_valid, 0);
    m_byte(8'hA5, a, h);
    chk("R9 ack while count nonzero", a, 1);
    chk("R5 byte valid", rx_valid, 1);
    chk("R5 byte value", rx_data, 8'hA5);
    chk("R9 count decremented", cnt_q, 1);
    pulse(rx_ready);
    chk("R5 ready empties buffer", rx_valid, 0);
    m_byte(8'h3C, a, h);
    chk("R9 ack on last counted byte", a, 1);
    chk("R9 count reaches zero", cnt_q, 0);
    pulse(rx_ready);
    m_byte(8'h11, a, h);
    chk("R9 end-of-count value sent", a, 0);
    chk("R9 count stays zero", cnt_q, 0);
    chk("R5 byte still held", rx_valid, 1);
    pulse(clr_buf);
    chk("R5 clear drops byte", rx_valid, 0);
    m_stop();
  endtask

  task automatic t_addr_to_buf();
    bit a, h;
    addr_to_buf = 1;
    m_start();
    m_byte(8'hB4, a, h);
    chk("R3 address byte in buffer valid", rx_valid, 1);
    chk("R3 address byte value", rx_data, 8'hB4);
    m_stop();
    pulse(clr_buf);
    addr_to_buf = 0;
  endtask

  task automatic t_addr_hold();
    bit a, h;
    addr_hold_en = 1;
    m_start();
    for (int i = 7; i >= 0; i--) m_bit(bit'(8'hB4 >> i), h);
    m_ack(h, a);
    chk("R4 SCL held after address", h, 1);
    chk("R4 stretch flag", stretch_flag, 1);
    chk("R4 irq raised", irq, 1);
    chk("R4 ack already on SDA", sda_line, 0);
    pulse(clr_stretch);
    m_finish_ack(a);
    chk("R4 ack after release", a, 1);
    chk("R4 flag cleared", stretch_flag, 0);
    m_stop();
    addr_hold_en = 0;
  endtask

  task automatic t_overflow_stretch();
    bit a, h;
    logic [7:0] d = 8'h3E;
    load_cnt(5);
    m_start();
    m_byte(8'hB4, a, h);
    m_byte(8'hC3, a, h);
    for (int i = 7; i >= 1; i--) m_bit(d[i], h);
    chk("R6 no hold before 7th fall", h, 0);
    m_bit(d[0], h);
    chk("R6 SCL held after 7th fall", h, 1);
    chk("R6 stretch flag set", stretch_flag, 1);
    chk("R6 old byte intact", rx_data, 8'hC3);
    pulse(rx_ready);
    tick(4);
    chk("R6 flag cleared by read", stretch_flag, 0);
    chk("R6 SCL released", scl_line, 1);
    m_finish();
    m_ack(h, a);
    chk("R6 byte acked after stretch", a, 1);
    chk("R6 new byte stored", rx_data, 8'h3E);
    m_stop();
    pulse(clr_buf);
  endtask

  task automatic t_overflow_nack();
    bit a, h;
    stretch_dis = 1; addr_hold_en = 1;
    load_cnt(5);
    m_start();
    m_byte(8'hB4, a, h);
    chk("R11 no address hold", h, 0);
    chk("R11 no stretch flag", stretch_flag, 0);
    m_byte(8'h12, a, h);
    chk("R7 first byte acked", a, 1);
    m_byte(8'h34, a, h);
    chk("R7 overflow NACK", a, 0);
    chk("R11 no overflow hold", h, 0);
    chk("R7 nack flag", nack_flag, 1);
    chk("R7 buffer keeps old byte", rx_data, 8'h12);
    m_byte(8'h56, a, h);
    chk("R7 bus ignored after NACK", a, 0);
    m_stop();
    pulse(clr_nack);
    chk("R7 nack flag cleared", nack_flag, 0);
    pulse(clr_buf);
    stretch_dis = 0; addr_hold_en = 0;
  endtask

  task automatic t_ack_hold();
    bit a, h;
    ack_hold_en = 1;
    load_cnt(5);
    m_start();
    m_byte(8'hB4, a, h);
    chk("R8 no hold on address", h, 0);
    for (int i = 7; i >= 0; i--) m_bit(bit'(8'h77 >> i), h);
    m_ack(h, a);
    chk("R8 held before ack slot", h, 1);
    chk("R8 acktime flag", acktime_flag, 1);
    chk("R8 stretch flag", stretch_flag, 1);
    chk("R8 byte readable", rx_data, 8'h77);
    ack_data = 1;
    tick(4);
    pulse(clr_stretch);
    tick(40);
    chk("R8 still held with acktime pending", scl_line, 0);
    pulse(clr_acktime);
    m_finish_ack(a);
    chk("R8 chosen NACK sent", a, 0);
    chk("R9 no decrement on NACK", cnt_q, 5);
    m_stop();
    pulse(rx_ready);
    ack_data = 0; ack_hold_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1;
    tick(5);
    t_reset();
    t_mismatch();
    t_read_req();
    t_write_count();
    t_addr_to_buf();
    t_addr_hold();
    t_overflow_stretch();
    t_overflow_nack();
    t_ack_hold();
    chk("R10 SDA moved only with SCL low", r10_viol, 0);
    report();
    $finish;
  end

endmodule